// File: doc/BRIEF.md
# EEPROM Programming Control Sequencer

This block governs a small byte-wide non-volatile array of `ARRAY_BYTES` cells plus one extra configuration byte that lives one slot past the last cell. A CPU reaches it over a simple register bus: an address, a read strobe, a write strobe, an 8-bit write bus and a registered 8-bit read bus. The address space splits into a register half (control register at offset 0, configuration register at offset 1) and an array window.

Changing a cell takes a strict sequence. Software first sets the latch-enable bit, then writes one byte to the array (or to the configuration register), which captures a target and a data byte. Next it raises the programming-voltage bit, which starts an on-time counter. When the voltage bit is dropped again, the block either ANDs the latched byte into the target, or erases a byte, a 16-byte row or the whole store to 0xFF, provided the voltage stayed on for at least `MIN_CYCLES` clocks. Any break in the sequence is reported as a one-cycle error pulse carrying a 3-bit code.

The controller is a three-state machine. `S_IDLE` holds no target. The transition *latch* (accepted data write) leads to `S_ARMED`. From there, *arm* (voltage bit newly set) leads to `S_HV`, and *drop* (latch-enable cleared) returns to `S_IDLE`. From `S_HV`, *commit* (voltage cleared after enough cycles) and *abort* (voltage cleared too early) both return to `S_IDLE`.

Top module: `eeprom_prog_seq`

## Requirements
- R1: `bus_addr[IDX_W]`=1 selects the array window with the cell index in the low `IDX_W` bits. Otherwise offset 0 is the control register and offset 1 the configuration register. Other register offsets read 0 and ignore writes. Control bits: 4 byte mode, 3 row mode, 2 erase, 1 latch enable, 0 programming voltage; bits 7..5 read 0. `bus_rdata` carries the read result in the cycle after `bus_rd`, and 0 in every other cycle.
- R2: Reset clears the control register and any latched target. It loads the live configuration register from the stored configuration byte and keeps the cell contents. At power-up every cell and the configuration byte read as 0xFF.
- R3: A control write that sets latch enable and voltage together while both were clear is rejected with code 1, and the control register is left unchanged.
- R4: A control write with the voltage bit set is rejected with code 2 if latch enable is clear in either the old value or the written value. It is rejected with code 3 if the voltage bit is newly set with no target latched.
- R5: A write to the array window or to the configuration register while latch enable is clear gives code 5. The same write while a target is already latched gives code 6. Otherwise it latches the target and the data. A configuration-register write targets the configuration byte.
- R6: Clearing the voltage bit when fewer than `MIN_CYCLES` clock edges have passed since it was set gives code 4, leaves the store unchanged and discards the target. Exactly `MIN_CYCLES` edges is enough.
- R7: With the erase bit clear, completion ANDs the latched byte into the target, so bits only go from 1 to 0.
- R8: With erase set, byte mode, or a configuration-byte target, sets just the target to 0xFF.
- R9: With erase set, row mode and not byte mode, sets to 0xFF the 16 cells whose index equals the target index with its low 4 bits cleared.
- R10: With erase set and neither mode bit set, sets every cell and the configuration byte to 0xFF.
- R11: An array-window read while latch enable is set gives code 7 and returns 0.
- R12: When bit 0 of the live configuration register is 0, array-window reads return 0 and array-window writes are ignored without error. A newly programmed configuration byte takes effect only after the next reset.
- R13: `err_pulse` is high for exactly one cycle, the cycle after the offending access, with the code on `err_code`. Otherwise `err_code` is 0. Clearing latch enable discards a latched target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | IDX_W+1 | Register/array address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| err_pulse | output | 1 | One-cycle sequencing error flag |
| err_code | output | 3 | Violated rule code (0 when no error) |

## Verification
The bench builds the block with `ARRAY_BYTES`=64 and `MIN_CYCLES`=20. With a 64-cell array, a bulk erase and a read-back of the boundary rows stay short. A 20-cycle minimum lets the bench place voltage-off writes at 19, 20 and 26 elapsed edges, which covers both sides of the on-time limit. The configuration byte sits at index 64, so the bench can program it, disable the array and re-enable it across resets within a few hundred cycles.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_HV    = 2'd2
    } seq_state_t;

    typedef enum logic [2:0] {
        E_NONE      = 3'd0,
        E_BOTH_SET  = 3'd1,
        E_NO_LATCH  = 3'd2,
        E_NO_TARGET = 3'd3,
        E_SHORT     = 3'd4,
        E_WR_LOCKED = 3'd5,
        E_WR_TWICE  = 3'd6,
        E_RD_BUSY   = 3'd7
    } err_code_t;

    typedef enum logic [1:0] {
        OP_PROG       = 2'd0,
        OP_ERASE_BYTE = 2'd1,
        OP_ERASE_ROW  = 2'd2,
        OP_ERASE_ALL  = 2'd3
    } cell_op_t;

    localparam int CB_PGM   = 0;
    localparam int CB_LAT   = 1;
    localparam int CB_ERASE = 2;
    localparam int CB_ROW   = 3;
    localparam int CB_BYTE  = 4;
    localparam logic [7:0] CTRL_MASK = 8'h1F;
    localparam int ROW_BYTES = 16;
    localparam int CFG_ENABLE_BIT = 0;

endpackage

// File: rtl/eeprom_ontime_ctr.sv
module eeprom_ontime_ctr #(
    parameter int MIN_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(MIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_CYCLES);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= ONE;
        end else if (run && (cnt_q < LIMIT)) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign expired = (cnt_q >= LIMIT);

    // R6: the on-time count saturates at the limit
    p_ctr_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    // R6: a started count never reports expiry on the following cycle unless the limit is 1
    p_start_fresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (MIN_CYCLES > 1)) |=> !expired);

endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array
    import eeprom_seq_pkg::*;
#(
    parameter int ARRAY_BYTES = 512,
    localparam int IDX_W  = $clog2(ARRAY_BYTES),
    localparam int SLOT_W = $clog2(ARRAY_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_go,
    input  cell_op_t          op_kind,
    input  logic [SLOT_W-1:0] op_idx,
    input  logic [7:0]        op_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_byte,
    output logic [7:0]        cfg_byte
);
    // Cells hold the complement of their value: an all-zero power-up
    // state reads as the erased value 0xFF.
    logic [7:0] inv_q [ARRAY_BYTES+1];

    always_ff @(posedge clk) begin
        if (op_go) begin
            for (int i = 0; i <= ARRAY_BYTES; i++) begin
                unique case (op_kind)
                    OP_PROG: begin
                        if (SLOT_W'(i) == op_idx)
                            inv_q[i] <= inv_q[i] | ~op_data;
                    end
                    OP_ERASE_BYTE: begin
                        if (SLOT_W'(i) == op_idx)
                            inv_q[i] <= 8'h00;
                    end
                    OP_ERASE_ROW: begin
                        if ((i < ARRAY_BYTES) &&
                            ((i / ROW_BYTES) == (int'(op_idx) / ROW_BYTES)))
                            inv_q[i] <= 8'h00;
                    end
                    OP_ERASE_ALL: begin
                        inv_q[i] <= 8'h00;
                    end
                endcase
            end
        end
    end

    assign rd_byte  = ~inv_q[rd_idx];
    assign cfg_byte = ~inv_q[ARRAY_BYTES];

    // R10: without an operation the configuration byte holds its value
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_go |=> $stable(cfg_byte));

    // R7: a program operation never sets a bit of the configuration byte
    p_prog_clears_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_kind == OP_PROG) |=> ((cfg_byte & ~$past(cfg_byte)) == 8'h00));

endmodule

// File: rtl/eeprom_seq_fsm.sv
module eeprom_seq_fsm
    import eeprom_seq_pkg::*;
#(
    parameter int ARRAY_BYTES = 512,
    localparam int IDX_W  = $clog2(ARRAY_BYTES),
    localparam int SLOT_W = $clog2(ARRAY_BYTES + 1),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              hv_expired,
    input  logic [7:0]        cfg_stored,
    output logic              ctr_start,
    output logic              ctr_run,
    output logic              op_go,
    output cell_op_t          op_kind,
    output logic [SLOT_W-1:0] op_idx,
    output logic [7:0]        op_data,
    output logic [7:0]        ctrl_q,
    output logic [7:0]        cfg_live_q,
    output logic              array_mapped,
    output logic              err_valid_q,
    output err_code_t         err_code_q
);
    localparam logic [SLOT_W-1:0] CFG_SLOT = SLOT_W'(ARRAY_BYTES);

    seq_state_t        state_q, state_d;
    logic [7:0]        ctrl_d;
    logic [SLOT_W-1:0] tgt_q, tgt_d;
    logic [7:0]        data_q, data_d;
    err_code_t         err_d;
    logic              pending;

    logic             in_window;
    logic [IDX_W-1:0] offset;
    logic             hit_ctrl, hit_cfg, hit_cell;
    logic             old_lat, old_pgm, new_lat, new_pgm;
    logic [7:0]       new_ctrl;

    assign in_window    = addr[ADDR_W-1];
    assign offset       = addr[IDX_W-1:0];
    assign array_mapped = cfg_live_q[CFG_ENABLE_BIT];
    assign hit_ctrl     = !in_window && (offset == '0);
    assign hit_cfg      = !in_window && (offset == IDX_W'(1));
    assign hit_cell     = in_window && array_mapped;
    assign new_ctrl     = wr_data & CTRL_MASK;
    assign old_lat      = ctrl_q[CB_LAT];
    assign old_pgm      = ctrl_q[CB_PGM];
    assign new_lat      = new_ctrl[CB_LAT];
    assign new_pgm      = new_ctrl[CB_PGM];

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            ctrl_q      <= 8'h00;
            tgt_q       <= '0;
            data_q      <= 8'h00;
            cfg_live_q  <= cfg_stored;
            err_code_q  <= E_NONE;
            err_valid_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            ctrl_q      <= ctrl_d;
            tgt_q       <= tgt_d;
            data_q      <= data_d;
            err_code_q  <= err_d;
            err_valid_q <= (err_d != E_NONE);
        end
    end

    // Next-state process
    always_comb begin
        state_d   = state_q;
        ctrl_d    = ctrl_q;
        tgt_d     = tgt_q;
        data_d    = data_q;
        err_d     = E_NONE;
        op_go     = 1'b0;
        ctr_start = 1'b0;
        if (wr_en) begin
            if (hit_ctrl) begin
                if (new_lat && new_pgm && !old_lat && !old_pgm) begin
                    err_d = E_BOTH_SET;
                end else if (new_pgm && (!old_lat || !new_lat)) begin
                    err_d = E_NO_LATCH;
                end else if (new_pgm && !old_pgm && !pending) begin
                    err_d = E_NO_TARGET;
                end else begin
                    ctrl_d = new_ctrl;
                    if (old_pgm && !new_pgm) begin
                        // commit or abort
                        if (hv_expired) op_go = 1'b1;
                        else            err_d = E_SHORT;
                        state_d = S_IDLE;
                    end else if (new_pgm && !old_pgm) begin
                        // arm
                        state_d   = S_HV;
                        ctr_start = 1'b1;
                    end else if (!new_lat) begin
                        // drop
                        state_d = S_IDLE;
                    end
                end
            end else if (hit_cfg || hit_cell) begin
                if (!old_lat) begin
                    err_d = E_WR_LOCKED;
                end else if (pending) begin
                    err_d = E_WR_TWICE;
                end else begin
                    // latch
                    state_d = S_ARMED;
                    tgt_d   = hit_cfg ? CFG_SLOT : SLOT_W'(offset);
                    data_d  = wr_data;
                end
            end
        end else if (rd_en && hit_cell && old_lat) begin
            err_d = E_RD_BUSY;
        end
    end

    // Output process
    always_comb begin
        unique case (state_q)
            S_IDLE:  begin pending = 1'b0; ctr_run = 1'b0; end
            S_ARMED: begin pending = 1'b1; ctr_run = 1'b0; end
            S_HV:    begin pending = 1'b1; ctr_run = 1'b1; end
            default: begin pending = 1'b0; ctr_run = 1'b0; end
        endcase
        op_idx  = tgt_q;
        op_data = data_q;
        if (!ctrl_q[CB_ERASE])
            op_kind = OP_PROG;
        else if (ctrl_q[CB_BYTE] || (tgt_q == CFG_SLOT))
            op_kind = OP_ERASE_BYTE;
        else if (ctrl_q[CB_ROW])
            op_kind = OP_ERASE_ROW;
        else
            op_kind = OP_ERASE_ALL;
    end

    // R4: the voltage bit is never held without latch enable
    p_pgm_needs_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CB_PGM] |-> ctrl_q[CB_LAT]);

    // R6: the counting state and the voltage bit agree
    p_hv_tracks_pgm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HV) == ctrl_q[CB_PGM]);

    // R13: a completed operation leaves no target latched
    p_idle_after_commit_r13: assert property (@(posedge clk) disable iff (!rst_n)
        op_go |=> (state_q == S_IDLE));

    // R12: the live configuration only changes through reset
    p_cfg_live_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_live_q));

endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq
    import eeprom_seq_pkg::*;
#(
    parameter int ARRAY_BYTES = 512,
    parameter int MIN_CYCLES  = 10000,
    localparam int IDX_W  = $clog2(ARRAY_BYTES),
    localparam int SLOT_W = $clog2(ARRAY_BYTES + 1),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              err_pulse,
    output logic [2:0]        err_code
);
    logic              ctr_start, ctr_run, hv_expired;
    logic              op_go;
    cell_op_t          op_kind;
    logic [SLOT_W-1:0] op_idx;
    logic [7:0]        op_data;
    logic [7:0]        ctrl_q, cfg_live_q, cfg_stored, cell_byte;
    logic              array_mapped, err_valid_q;
    err_code_t         err_code_q;
    logic [7:0]        rd_d, rd_q;

    eeprom_seq_fsm #(.ARRAY_BYTES(ARRAY_BYTES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (bus_addr),
        .rd_en       (bus_rd),
        .wr_en       (bus_wr),
        .wr_data     (bus_wdata),
        .hv_expired  (hv_expired),
        .cfg_stored  (cfg_stored),
        .ctr_start   (ctr_start),
        .ctr_run     (ctr_run),
        .op_go       (op_go),
        .op_kind     (op_kind),
        .op_idx      (op_idx),
        .op_data     (op_data),
        .ctrl_q      (ctrl_q),
        .cfg_live_q  (cfg_live_q),
        .array_mapped(array_mapped),
        .err_valid_q (err_valid_q),
        .err_code_q  (err_code_q)
    );

    eeprom_ontime_ctr #(.MIN_CYCLES(MIN_CYCLES)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (ctr_start),
        .run    (ctr_run),
        .expired(hv_expired)
    );

    eeprom_cell_array #(.ARRAY_BYTES(ARRAY_BYTES)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_go   (op_go),
        .op_kind (op_kind),
        .op_idx  (op_idx),
        .op_data (op_data),
        .rd_idx  (bus_addr[IDX_W-1:0]),
        .rd_byte (cell_byte),
        .cfg_byte(cfg_stored)
    );

    always_comb begin
        rd_d = 8'h00;
        if (bus_rd && !bus_wr) begin
            if (bus_addr[ADDR_W-1]) begin
                if (array_mapped && !ctrl_q[CB_LAT])
                    rd_d = cell_byte;
            end else if (bus_addr[IDX_W-1:0] == '0) begin
                rd_d = ctrl_q;
            end else if (bus_addr[IDX_W-1:0] == IDX_W'(1)) begin
                rd_d = cfg_live_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 8'h00;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q;
    assign err_pulse = err_valid_q;
    assign err_code  = err_code_q;

    // R13: no code is shown outside an error pulse
    p_code_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !err_pulse |-> (err_code == 3'd0));

    // R13: an idle bus cycle never produces an error
    p_no_access_no_err_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |=> !err_pulse);

    // R12: a disabled array returns zero on reads of its window
    p_unmapped_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr[ADDR_W-1] && !cfg_live_q[CFG_ENABLE_BIT])
        |=> (bus_rdata == 8'h00));

    // R1: control reads never show the unused upper bits
    p_ctrl_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == '0) |=> (bus_rdata[7:5] == 3'b000));

endmodule

// File: tb/tb_eeprom_prog_seq.sv
module tb_eeprom_prog_seq;
    localparam int N     = 64;
    localparam int MINC  = 20;
    localparam int AW    = 7;
    localparam int WIN   = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic          err_pulse;
    logic [2:0]    err_code;

    int total = 0;
    int bad   = 0;
    string cur_req = "R2";

    // behavioural reference model
    int m [0:N];
    int ctrl, pend, tgt, pdat, cfg_live, set_cyc, now;
    int last_err;

    always #5 clk = ~clk;

    eeprom_prog_seq #(.ARRAY_BYTES(N), .MIN_CYCLES(MINC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_pulse(err_pulse), .err_code(err_code)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_apply(input int o);
        if (((o >> 2) & 1) == 0) begin
            m[tgt] = m[tgt] & pdat;
        end else if (((o >> 4) & 1) == 1 || tgt == N) begin
            m[tgt] = 255;
        end else if (((o >> 3) & 1) == 1) begin
            for (int j = 0; j < 16; j++)
                if ((tgt & ~15) + j < N) m[(tgt & ~15) + j] = 255;
        end else begin
            for (int j = 0; j <= N; j++) m[j] = 255;
        end
    endtask

    task automatic cyc(input bit r, input bit w, input int a, input int d);
        int e, rd, idx, v, ol, op, nl, np;
        bit win;
        bus_rd = r; bus_wr = w; bus_addr = AW'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        now++;
        e = 0; rd = 0;
        win = (a >= WIN); idx = a % WIN;
        ol = (ctrl >> 1) & 1; op = ctrl & 1;
        if (w) begin
            if (!win && idx == 0) begin
                v = d & 31; nl = (v >> 1) & 1; np = v & 1;
                if (nl && np && !ol && !op) e = 1;
                else if (np && (!ol || !nl)) e = 2;
                else if (np && !op && !pend) e = 3;
                else begin
                    if (op && !np) begin
                        if (now - set_cyc >= MINC) model_apply(ctrl);
                        else e = 4;
                        pend = 0;
                    end else if (np && !op) begin
                        set_cyc = now;
                    end
                    if (!nl) pend = 0;
                    ctrl = v;
                end
            end else if ((!win && idx == 1) || (win && (cfg_live & 1))) begin
                if (!ol) e = 5;
                else if (pend) e = 6;
                else begin pend = 1; tgt = win ? idx : N; pdat = d; end
            end
        end else if (r) begin
            if (win) begin
                if (cfg_live & 1) begin
                    if (ol) e = 7; else rd = m[idx];
                end
            end else if (idx == 0) rd = ctrl;
            else if (idx == 1) rd = cfg_live;
        end
        last_err = e;
        check({cur_req, " rdata"}, int'(bus_rdata), rd);
        check({cur_req, " errcode"}, int'(err_code), e);
        check({cur_req, " errpulse"}, int'(err_pulse), (e != 0) ? 1 : 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    task automatic wr(input int a, input int d); cyc(0, 1, a, d); endtask

    task automatic rd_expect(input int a, input int v);
        cyc(1, 0, a, 0);
        check({cur_req, " literal read"}, int'(bus_rdata), v);
    endtask

    task automatic err_expect(input int code);
        check({cur_req, " literal code"}, last_err, code);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        ctrl = 0; pend = 0; cfg_live = m[N];
    endtask

    task automatic hv_op(input int mode, input int a, input int d, input int wait_n);
        wr(0, mode | 2);
        wr(a, d);
        wr(0, mode | 3);
        idle(wait_n);
        wr(0, mode | 2);
        wr(0, 0);
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int j = 0; j <= N; j++) m[j] = 255;
        now = 0; set_cyc = 0; last_err = 0;
        @(negedge clk);
        do_reset();

        cur_req = "R2";
        rd_expect(0, 8'h00);
        rd_expect(1, 8'hFF);
        rd_expect(WIN + 0, 8'hFF);

        cur_req = "R1";
        rd_expect(5, 8'h00);
        wr(0, 8'hE2);
        rd_expect(0, 8'h02);
        wr(0, 0);

        cur_req = "R7";
        hv_op(0, WIN + 5, 8'hA5, 25);
        rd_expect(WIN + 5, 8'hA5);
        hv_op(0, WIN + 5, 8'h3C, 25);
        rd_expect(WIN + 5, 8'h24);

        cur_req = "R6";
        hv_op(0, WIN + 5, 8'h00, 5);
        rd_expect(WIN + 5, 8'h24);
        hv_op(0, WIN + 6, 8'h0F, MINC - 1);
        rd_expect(WIN + 6, 8'h0F);
        hv_op(0, WIN + 6, 8'h00, MINC - 2);
        rd_expect(WIN + 6, 8'h0F);

        cur_req = "R3";
        wr(0, 8'h03);
        err_expect(1);
        rd_expect(0, 8'h00);

        cur_req = "R4";
        wr(0, 8'h01);
        err_expect(2);
        wr(0, 8'h02);
        wr(0, 8'h03);
        err_expect(3);
        wr(0, 0);

        cur_req = "R5";
        wr(WIN + 9, 8'h00);
        err_expect(5);
        wr(1, 8'h00);
        err_expect(5);
        wr(0, 8'h02);
        wr(WIN + 9, 8'h11);
        wr(WIN + 10, 8'h22);
        err_expect(6);
        wr(0, 0);

        cur_req = "R11";
        wr(0, 8'h02);
        rd_expect(WIN + 5, 8'h00);
        err_expect(7);
        wr(0, 0);

        cur_req = "R13";
        wr(0, 8'h02);
        wr(WIN + 9, 8'h00);
        wr(0, 0);
        wr(0, 8'h02);
        wr(WIN + 9, 8'h00);
        err_expect(0);
        idle(1);
        wr(0, 0);

        cur_req = "R8";
        hv_op(8'h14, WIN + 5, 0, 25);
        rd_expect(WIN + 5, 8'hFF);

        cur_req = "R9";
        hv_op(0, WIN + 17, 8'h00, 25);
        hv_op(0, WIN + 31, 8'h11, 25);
        hv_op(0, WIN + 32, 8'h22, 25);
        hv_op(0, WIN + 15, 8'h33, 25);
        hv_op(8'h0C, WIN + 20, 0, 25);
        rd_expect(WIN + 16, 8'hFF);
        rd_expect(WIN + 17, 8'hFF);
        rd_expect(WIN + 31, 8'hFF);
        rd_expect(WIN + 32, 8'h22);
        rd_expect(WIN + 15, 8'h33);

        cur_req = "R12";
        hv_op(0, 1, 8'hFE, 25);
        rd_expect(1, 8'hFF);
        do_reset();
        rd_expect(1, 8'hFE);
        rd_expect(WIN + 32, 8'h00);
        wr(0, 8'h02);
        wr(WIN + 32, 8'h00);
        err_expect(0);
        wr(0, 0);
        hv_op(8'h14, 1, 0, 25);
        do_reset();
        rd_expect(1, 8'hFF);
        cur_req = "R2";
        rd_expect(WIN + 32, 8'h22);

        cur_req = "R10";
        hv_op(0, 1, 8'h7F, 25);
        hv_op(8'h04, WIN + 40, 0, 25);
        rd_expect(WIN + 32, 8'hFF);
        rd_expect(WIN + 6, 8'hFF);
        rd_expect(WIN + 15, 8'hFF);
        do_reset();
        rd_expect(1, 8'hFF);

        idle(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule